// File: doc/BRIEF.md
# Dual-group ADC register interface

This block sits on an 8-bit I/O bus and controls two converter groups. Each group is a successive-approximation converter with an 8-way input multiplexer. The block claims a 16-byte window whose position is set by a 12-bit configuration value, compared against address bits 15:4. Writing a control byte to a group latches that group's channel, range, polarity, acquisition and power settings. The same write starts an internally timed acquisition, which is followed by a fixed-length conversion.

At the end of a conversion the block captures the group's 12-bit sample input and clears the group's bit in the shared status register. It also raises that group's interrupt request. Software reads each result as two bytes. The upper byte carries the four high result bits, with the unused top nibble filled according to the polarity mode. The interrupt pin is driven only while at least one request is pending, so several cards can share one line.

The analog conversion itself is not part of the block. The latched control byte goes out to the analog side on the `grp_cfg` bus, and the sample value comes back in on `smp_in`.

Top module: `adc_bus_frontend`

## Requirements
- R1: A bus access hits only when bus_addr[15:4] equals base_cfg bit for bit. A write that misses starts no conversion, and a read that misses returns 0x00.
- R2: A write that hits at offset 0 targets group 0, and one at offset 2 targets group 1. Such a write latches the byte onto that group's 8-bit slice of grp_cfg (group 0 in bits 7:0) and starts the group's acquisition.
- R3: A group's status bit reads 1 from the clock edge that takes the control write until 18 clock edges later (6 acquisition plus 12 conversion). It reads 0 from then on. A status read taken on the 18th edge after the write still returns 1, and a read taken on the 19th returns 0.
- R4: A control write to a group that is still acquiring or converting abandons that operation and restarts the full 18-cycle sequence from the new write.
- R5: The result is captured from the group's sample input on the last conversion edge. A read at offset 0 (group 0) or offset 2 (group 1) returns result bits 7:0.
- R6: A read at offset 1 (group 0) or offset 3 (group 1) returns result bits 11:8 in bits 3:0. Bits 7:4 read 0000 when control bit 3 (polarity) was 0 and 1111 when it was 1.
- R7: A read at offset 8 returns the busy flag of group 0 in bit 0 and of group 1 in bit 1, with the other bits 0. Reads at offsets other than 0, 1, 2, 3 and 8 return 0x00.
- R8: Control bits 7:6 set the power mode. Values 10 and 11 put the group into power-down, but grp_sleep rises only when the conversion finishes, never during it. Values 00 and 01 keep the group awake. The next control write clears grp_sleep on the same edge, and results stay readable while the group is asleep.
- R9: A group's interrupt request sets when its conversion finishes. A read of that group's high byte clears it, and so does a new control write to that group. A read of the other group's high byte leaves it unchanged.
- R10: irq_oe is 1 exactly when at least one group request is pending. While irq_oe is 1, irq_o is driven 1; otherwise it is released to high impedance.
- R11: After reset, both status bits, all result bytes, irq_oe and grp_sleep are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_cfg | input | 12 | Required value of address bits 15:4 |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 8 | Write data (control byte) |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Registered read data, valid the cycle after the strobe |
| smp_in | input | 24 | Sample value of each group, group 0 in bits 11:0 |
| grp_cfg | output | 16 | Latched control byte of each group, group 0 in bits 7:0 |
| grp_sleep | output | 2 | Power-down state of each group |
| irq_oe | output | 1 | Interrupt driver enable |
| irq_o | output | 1 | Shareable interrupt pin, high impedance when idle |

## Verification
The checks assume that the bus strobes are single-cycle pulses and that reads and writes never assert in the same cycle. They also assume that base_cfg stays constant while the bus is active. The stimulus drives every access from tasks that raise exactly one strobe for one cycle, and it sets base_cfg once, during reset. The bench changes the sample inputs during acquisition and conversion, but only some cycles before the capture edge, so the captured value is well defined.

// File: rtl/adc_fe_pkg.sv
package adc_fe_pkg;

  typedef enum logic [1:0] {
    GS_IDLE  = 2'd0,
    GS_ACQ   = 2'd1,
    GS_CONV  = 2'd2,
    GS_SLEEP = 2'd3
  } grp_state_t;

  // control byte field positions that the sequencer and read path decode
  localparam int CTL_W       = 8;
  localparam int PD_HI_BIT   = 7;
  localparam int POL_BIT     = 3;

endpackage

// File: rtl/adc_fe_decode.sv
module adc_fe_decode #(
  parameter int ADDR_W  = 16,
  parameter int OFF_W   = 4,
  parameter int NUM_GRP = 2,
  localparam int BASE_W = ADDR_W - OFF_W
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [BASE_W-1:0]  base_cfg,
  input  logic               wr,
  input  logic               rd,
  output logic               rd_hit,
  output logic [OFF_W-1:0]   off,
  output logic [NUM_GRP-1:0] ctl_we,
  output logic [NUM_GRP-1:0] hi_rd
);

  logic hit;

  assign hit    = (addr[ADDR_W-1:OFF_W] == base_cfg);
  assign off    = addr[OFF_W-1:0];
  assign rd_hit = rd && hit;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_sel
    assign ctl_we[g] = wr && hit && (off == OFF_W'(2 * g));
    assign hi_rd[g]  = rd && hit && (off == OFF_W'(2 * g + 1));
  end

endmodule

// File: rtl/adc_fe_group.sv
module adc_fe_group
  import adc_fe_pkg::*;
#(
  parameter int RES_W    = 12,
  parameter int ACQ_CYC  = 6,
  parameter int CONV_CYC = 12,
  localparam int CNT_MAX = (ACQ_CYC > CONV_CYC) ? ACQ_CYC : CONV_CYC,
  localparam int CNT_W   = $clog2(CNT_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_byte,
  input  logic             hi_rd,
  input  logic [RES_W-1:0] smp,
  output logic             busy,
  output logic             sleep,
  output logic             irq,
  output logic [CTL_W-1:0] cfg,
  output logic [RES_W-1:0] result
);

  grp_state_t       st;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= GS_IDLE;
      cnt    <= '0;
      cfg    <= '0;
      result <= '0;
      irq    <= 1'b0;
    end else if (ctl_we) begin
      // a fresh write always restarts, aborting any running sequence
      cfg <= ctl_byte;
      st  <= GS_ACQ;
      cnt <= '0;
      irq <= 1'b0;
    end else begin
      if (hi_rd) irq <= 1'b0;
      case (st)
        GS_ACQ: begin
          if (cnt == CNT_W'(ACQ_CYC - 1)) begin
            st  <= GS_CONV;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        GS_CONV: begin
          if (cnt == CNT_W'(CONV_CYC - 1)) begin
            result <= smp;
            irq    <= 1'b1;
            cnt    <= '0;
            // power-down request honoured only once conversion is over
            st     <= cfg[PD_HI_BIT] ? GS_SLEEP : GS_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign busy  = (st == GS_ACQ) || (st == GS_CONV);
  assign sleep = (st == GS_SLEEP);

endmodule

// File: rtl/adc_bus_frontend.sv
module adc_bus_frontend
  import adc_fe_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int OFF_W    = 4,
  parameter int DATA_W   = 8,
  parameter int RES_W    = 12,
  parameter int NUM_GRP  = 2,
  parameter int ACQ_CYC  = 6,
  parameter int CONV_CYC = 12,
  parameter int STAT_OFF = 8,
  localparam int BASE_W  = ADDR_W - OFF_W,
  localparam int FILL_W  = 2 * DATA_W - RES_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [BASE_W-1:0]        base_cfg,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  output logic [DATA_W-1:0]        bus_rdata,
  input  logic [NUM_GRP*RES_W-1:0] smp_in,
  output logic [NUM_GRP*CTL_W-1:0] grp_cfg,
  output logic [NUM_GRP-1:0]       grp_sleep,
  output logic                     irq_oe,
  output wire                      irq_o
);

  logic                            rd_hit;
  logic [OFF_W-1:0]                off;
  logic [NUM_GRP-1:0]              ctl_we;
  logic [NUM_GRP-1:0]              hi_rd;
  logic [NUM_GRP-1:0]              grp_busy;
  logic [NUM_GRP-1:0]              irq_req;
  logic [NUM_GRP-1:0][RES_W-1:0]   res;
  logic [NUM_GRP-1:0][CTL_W-1:0]   cfg_q;

  adc_fe_decode #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .NUM_GRP(NUM_GRP)
  ) u_dec (
    .addr    (bus_addr),
    .base_cfg(base_cfg),
    .wr      (bus_wr),
    .rd      (bus_rd),
    .rd_hit  (rd_hit),
    .off     (off),
    .ctl_we  (ctl_we),
    .hi_rd   (hi_rd)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    adc_fe_group #(
      .RES_W   (RES_W),
      .ACQ_CYC (ACQ_CYC),
      .CONV_CYC(CONV_CYC)
    ) u_grp (
      .clk     (clk),
      .rst     (rst),
      .ctl_we  (ctl_we[g]),
      .ctl_byte(bus_wdata[CTL_W-1:0]),
      .hi_rd   (hi_rd[g]),
      .smp     (smp_in[g*RES_W +: RES_W]),
      .busy    (grp_busy[g]),
      .sleep   (grp_sleep[g]),
      .irq     (irq_req[g]),
      .cfg     (cfg_q[g]),
      .result  (res[g])
    );
    assign grp_cfg[g*CTL_W +: CTL_W] = cfg_q[g];
  end

  // registered read path
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      bus_rdata <= '0;
      if (rd_hit) begin
        for (int g = 0; g < NUM_GRP; g++) begin
          if (off == OFF_W'(2 * g))
            bus_rdata <= res[g][DATA_W-1:0];
          if (off == OFF_W'(2 * g + 1))
            bus_rdata <= {{FILL_W{cfg_q[g][POL_BIT]}}, res[g][RES_W-1:DATA_W]};
        end
        if (off == OFF_W'(STAT_OFF))
          bus_rdata <= {{(DATA_W-NUM_GRP){1'b0}}, grp_busy};
      end
    end
  end

  assign irq_oe = |irq_req;
  assign irq_o  = irq_oe ? 1'b1 : 1'bz;

endmodule

// File: rtl/adc_fe_chk.sv
module adc_fe_chk #(
  parameter int ADDR_W   = 16,
  parameter int OFF_W    = 4,
  parameter int NUM_GRP  = 2,
  parameter int ACQ_CYC  = 6,
  parameter int CONV_CYC = 12,
  localparam int BASE_W  = ADDR_W - OFF_W,
  localparam int SPAN    = ACQ_CYC + CONV_CYC,
  localparam int SPAN_W  = $clog2(SPAN + 2)
) (
  input logic               clk,
  input logic               rst,
  input logic [BASE_W-1:0]  base_cfg,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_wr,
  input logic [NUM_GRP-1:0] busy,
  input logic [NUM_GRP-1:0] sleep,
  input logic [NUM_GRP-1:0] irq_req,
  input logic               irq_oe,
  input logic               irq_o
);

  logic [SPAN_W-1:0] span0;
  logic              wr0;
  logic              wr1;
  logic              miss;

  assign wr0  = bus_wr && (bus_addr == {base_cfg, OFF_W'(0)});
  assign wr1  = bus_wr && (bus_addr == {base_cfg, OFF_W'(2)});
  assign miss = bus_wr && (bus_addr[ADDR_W-1:OFF_W] != base_cfg);

  always_ff @(posedge clk) begin
    if (rst)                      span0 <= '0;
    else if (wr0)                 span0 <= '0;
    else if (busy[0] && span0 < SPAN_W'(SPAN + 1)) span0 <= span0 + 1'b1;
  end

  // R2
  start0_busy_chk: assert property (@(posedge clk) disable iff (rst)
    wr0 |=> busy[0]);

  // R2
  start1_busy_chk: assert property (@(posedge clk) disable iff (rst)
    wr1 |=> busy[1]);

  // R1
  miss_no_start_chk: assert property (@(posedge clk) disable iff (rst)
    (miss && !busy[0] && !busy[1]) |=> (busy == '0));

  // R3
  busy_span_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy[0]) |-> (span0 == SPAN_W'(SPAN)));

  // R9
  done_irq0_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy[0]) |-> irq_req[0]);

  // R9
  done_irq1_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy[1]) |-> irq_req[1]);

  // R10
  irq_drive_chk: assert property (@(posedge clk) disable iff (rst)
    irq_oe |-> (irq_o == 1'b1));

  // R8
  sleep_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (sleep & busy) == '0);

  // R8
  sleep_after_conv_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sleep[1]) |-> $fell(busy[1]));

endmodule

bind adc_bus_frontend adc_fe_chk #(
  .ADDR_W  (ADDR_W),
  .OFF_W   (OFF_W),
  .NUM_GRP (NUM_GRP),
  .ACQ_CYC (ACQ_CYC),
  .CONV_CYC(CONV_CYC)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .base_cfg(base_cfg),
  .bus_addr(bus_addr),
  .bus_wr  (bus_wr),
  .busy    (grp_busy),
  .sleep   (grp_sleep),
  .irq_req (irq_req),
  .irq_oe  (irq_oe),
  .irq_o   (irq_o)
);

// File: tb/adc_bus_frontend_tb.sv
`timescale 1ns/1ps
module adc_bus_frontend_tb;

  localparam logic [15:0] A_C0 = 16'h7A30;
  localparam logic [15:0] A_H0 = 16'h7A31;
  localparam logic [15:0] A_C1 = 16'h7A32;
  localparam logic [15:0] A_H1 = 16'h7A33;
  localparam logic [15:0] A_ST = 16'h7A38;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] base_cfg = 12'h7A3;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic [11:0] smp0 = '0;
  logic [11:0] smp1 = '0;
  logic [15:0] grp_cfg;
  logic [1:0]  grp_sleep;
  logic        irq_oe;
  wire         irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit fin = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  adc_bus_frontend u_dut (
    .clk      (clk),
    .rst      (rst),
    .base_cfg (base_cfg),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_rdata(bus_rdata),
    .smp_in   ({smp1, smp0}),
    .grp_cfg  (grp_cfg),
    .grp_sleep(grp_sleep),
    .irq_oe   (irq_oe),
    .irq_o    (irq_o)
  );

  task automatic chk(input logic [15:0] got, input logic [15:0] exp, input string tag);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // driver tasks: called at a negedge, return at the next negedge
  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    chk({15'd0, irq_oe}, {15'd0, e}, tag);
    if (e) chk({15'd0, irq_o}, 16'd1, tag);
  endtask

  // monitor: pops the scoreboard once per read strobe
  initial begin
    forever begin
      @(posedge clk);
      if (bus_rd) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL scoreboard: read with no expected item, got %h expected none", bus_rdata);
        end else begin
          chk({8'd0, bus_rdata}, {8'd0, exp_q.pop_front()}, tag_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;

    // R11 reset state
    rd(A_ST, 8'h00, "R11 status");
    rd(A_C0, 8'h00, "R11 low0");
    rd(A_H0, 8'h00, "R11 high0");
    chk_irq(1'b0, "R11 irq");
    chk({14'd0, grp_sleep}, 16'd0, "R11 sleep");

    // R2 R3 R5 R6: group 0 unipolar, sample changed before capture
    smp0 = 12'hABC;
    wr(A_C0, 8'h45);
    smp0 = 12'h3C5;
    chk({8'd0, grp_cfg[7:0]}, 16'h0045, "R2 cfg0");
    idle(16);
    rd(A_ST, 8'h01, "R3 edge17");
    rd(A_ST, 8'h01, "R3 edge18");
    rd(A_ST, 8'h00, "R3 edge19");
    chk_irq(1'b1, "R9 set");
    rd(A_C0, 8'hC5, "R5 low0");
    rd(A_H0, 8'h03, "R6 unipolar");
    chk_irq(1'b0, "R9 cleared by high read");

    // R7 R6: group 1 bipolar
    smp1 = 12'h812;
    wr(A_C1, 8'h4B);
    rd(A_ST, 8'h02, "R7 bit1");
    chk({8'd0, grp_cfg[15:8]}, 16'h004B, "R2 cfg1");
    idle(20);
    rd(A_ST, 8'h00, "R7 idle");
    rd(A_C1, 8'h12, "R5 low1");
    rd(A_H1, 8'hF8, "R6 bipolar");

    // R4 abort during conversion
    wr(A_C0, 8'h40);
    idle(9);
    wr(A_C0, 8'h41);
    idle(16);
    rd(A_ST, 8'h01, "R4 edge17");
    rd(A_ST, 8'h01, "R4 edge18");
    rd(A_ST, 8'h00, "R4 edge19");

    // R9 cleared by control write
    chk_irq(1'b1, "R9 pending");
    wr(A_C0, 8'h40);
    chk_irq(1'b0, "R9 cleared by write");
    idle(20);
    chk_irq(1'b1, "R10 driven");
    rd(A_H0, 8'h03, "R6 high0");
    chk_irq(1'b0, "R10 released");

    // R8 standby power-down
    smp1 = 12'h7FE;
    wr(A_C1, 8'hA1);
    idle(10);
    chk({15'd0, grp_sleep[1]}, 16'd0, "R8 awake mid conversion");
    idle(10);
    chk({15'd0, grp_sleep[1]}, 16'd1, "R8 asleep after");
    rd(A_C1, 8'hFE, "R8 low readable");
    rd(A_H1, 8'h07, "R8 high readable");
    wr(A_C1, 8'h01);
    chk({15'd0, grp_sleep[1]}, 16'd0, "R8 wake on write");
    idle(20);
    chk({15'd0, grp_sleep[1]}, 16'd0, "R8 stays awake");
    // full power-down, bipolar
    wr(A_C1, 8'hC9);
    idle(20);
    chk({15'd0, grp_sleep[1]}, 16'd1, "R8 full power-down");
    rd(A_H1, 8'hF7, "R6 bipolar asleep");
    wr(A_C1, 8'h40);
    idle(20);
    rd(A_H1, 8'h07, "R6 high1");

    // R1 address misses, R7 unmapped offsets
    wr(16'h7A20, 8'h40);
    wr(16'hFA30, 8'h40);
    rd(A_ST, 8'h00, "R1 miss write");
    rd(16'h7B30, 8'h00, "R1 miss read");
    rd(16'h7A35, 8'h00, "R7 unmapped 5");
    rd(16'h7A39, 8'h00, "R7 unmapped 9");

    // R7 R9: both groups together
    smp0 = 12'h001;
    smp1 = 12'hFFF;
    wr(A_C0, 8'h48);
    wr(A_C1, 8'h40);
    rd(A_ST, 8'h03, "R7 both busy");
    idle(20);
    chk_irq(1'b1, "R10 both pending");
    rd(A_H0, 8'hF0, "R6 bipolar0");
    chk_irq(1'b1, "R9 other group kept");
    rd(A_C1, 8'hFF, "R5 low1 full");
    rd(A_H1, 8'h0F, "R6 unipolar1");
    chk_irq(1'b0, "R10 none pending");

    wait (exp_q.size() == 0);
    idle(2);
    fin = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule